// File: doc/BRIEF.md
# MSI to Adapter Indicator Interrupt Bridge

This block receives message-signalled interrupt writes directed at one function's notification window and converts each into two single-bit set operations on indicator arrays held in memory. The first sets the bit belonging to the vector. The second sets the function's summary bit. Both arrays are addressed in bits, with the most significant bit of each byte counted first. Every set is issued as one byte-wide atomic OR request, and memory answers with the byte value it held before the OR. An adapter interrupt strobe, tagged with the function's interruption subclass, is raised only when that earlier summary byte was entirely zero. This means a summary already signalled does not interrupt again.

The data word of each write carries a function index in its upper bits and a vector number in its low bits. When no function is bound, the write produces an error event. When the function is bound but not enabled, the write is dropped. A memory access failure on either indicator produces an access error event. Reads of the window return all ones.

The controller is a single state machine. Its states are IDLE, IND_REQ, IND_FAIL, SUM_REQ, SUM_FAIL, NOFN_ERR and RAISE, and its transitions are as follows:
- IDLE goes to NOFN_ERR on an accepted write with no bound function.
- IDLE stays in IDLE on an accepted write to a function that is not enabled.
- IDLE goes to IND_REQ on an accepted write to an enabled function.
- IND_REQ goes to SUM_REQ on a good acknowledge, or to IND_FAIL on a failed acknowledge.
- IND_FAIL goes to SUM_REQ.
- SUM_REQ goes to RAISE on a good acknowledge with a zero prior byte, to IDLE on a good acknowledge with a nonzero prior byte, or to SUM_FAIL on a failed acknowledge.
- SUM_FAIL, NOFN_ERR and RAISE go to IDLE.

Top module: `msib_top`

## Requirements
- R1: The write data is split so that bits [31:11] are the function index and bits [10:0] are the vector number.
- R2: When `fn_bound` is low, an accepted write raises `err_valid` for exactly one cycle. The event carries code 8'h01, the index, the write address, and the vector shifted left by 4 in `err_field`. No memory request is made.
- R3: When `fn_bound` is high and `fn_enabled` is low, an accepted write causes no memory request, no event and no interrupt. `msi_ready` is high again in the next cycle.
- R4: The indicator request has byte address `ind_base + (ind_off + vector) / 8` and mask `8'h80 >> ((ind_off + vector) % 8)`.
- R5: The summary request has byte address `sum_base + sum_off / 8` and mask `8'h80 >> (sum_off % 8)`.
- R6: The indicator request is acknowledged before the summary request is issued. `msi_ready` stays low from acceptance until both updates are done.
- R7: A memory request keeps its address and mask unchanged until `mem_ack`.
- R8: `irq_strobe` pulses for one cycle, with `irq_isc` equal to `fn_isc`, only if the summary acknowledge was good and reported a prior byte of 8'h00. A nonzero prior byte suppresses the pulse, even when a different bit of that byte is set.
- R9: An acknowledge with `mem_err` high produces a one-cycle event with code 8'h02, with index, address and field all zero. After an indicator failure the summary update still runs. After a summary failure no interrupt is raised.
- R10: `rd_data` always reads 32'hffffffff.
- R11: After reset, `msi_ready` is high and `mem_req`, `irq_strobe` and `err_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Window write present |
| msi_addr | input | 32 | Window write address |
| msi_data | input | 32 | Window write data (index and vector) |
| msi_ready | output | 1 | Write accepted this cycle when valid |
| rd_data | output | 32 | Window read data |
| fn_bound | input | 1 | A function is bound to the window |
| fn_enabled | input | 1 | Bound function is in the enabled state |
| ind_base | input | 32 | Byte base of the vector indicator array |
| ind_off | input | 16 | Bit offset of vector 0 in that array |
| sum_base | input | 32 | Byte base of the summary array |
| sum_off | input | 16 | Bit offset of the summary bit |
| fn_isc | input | 3 | Interruption subclass of the function |
| mem_req | output | 1 | Byte OR request pending |
| mem_addr | output | 32 | Byte address of the request |
| mem_mask | output | 8 | Bits to OR into the byte |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Byte could not be accessed |
| mem_old | input | 8 | Byte value before the OR |
| irq_strobe | output | 1 | Adapter interrupt pulse |
| irq_isc | output | 3 | Subclass of the pulse |
| err_valid | output | 1 | Error event pulse |
| err_code | output | 8 | Event code |
| err_index | output | 21 | Function index of the event |
| err_addr | output | 32 | Window address of the event |
| err_field | output | 32 | Event detail field |

## Verification
On every cycle the assertions check the following: the response to an unbound or disabled function in the cycle after acceptance, the indicator request coming first for an enabled function, that request address and mask hold until acknowledge, and that an interrupt is always preceded by a clean summary acknowledge with a zero byte. Only the bench scenarios can show that the computed addresses and masks are right across byte boundaries. The same holds for an indicator and summary bit sharing one byte, where the first set makes the summary byte nonzero, and for a summary byte with only a foreign bit set. The bench scenarios also show the exact contents of each error event and the final state of indicator memory.

// File: rtl/msib_pkg.sv
package msib_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IND_REQ,
        ST_IND_FAIL,
        ST_SUM_REQ,
        ST_SUM_FAIL,
        ST_NOFN_ERR,
        ST_RAISE
    } msib_state_e;

    localparam logic [7:0] EVT_NO_FUNC    = 8'h01;
    localparam logic [7:0] EVT_IND_ACCESS = 8'h02;

endpackage

// File: rtl/msib_bitaddr.sv
module msib_bitaddr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int VEC_W  = 11
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        mask
);
    localparam int POS_W = ((OFF_W > VEC_W) ? OFF_W : VEC_W) + 1;

    logic [POS_W-1:0] pos;

    always_comb begin
        pos       = POS_W'(off) + POS_W'(vec);
        byte_addr = base + ADDR_W'(pos[POS_W-1:3]);
        mask      = 8'h80 >> pos[2:0];
    end
endmodule

// File: rtl/msib_ctrl_fsm.sv
module msib_ctrl_fsm
    import msib_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       msi_valid,
    input  logic       fn_bound,
    input  logic       fn_enabled,
    input  logic       mem_ack,
    input  logic       mem_err,
    input  logic [7:0] mem_old,
    output logic       msi_ready,
    output logic       accept,
    output logic       mem_req,
    output logic       sel_sum,
    output logic       irq_strobe,
    output logic       err_valid,
    output logic       err_access
);
    msib_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (msi_valid) begin
                    if (!fn_bound)       state_nx = ST_NOFN_ERR;
                    else if (fn_enabled) state_nx = ST_IND_REQ;
                    else                 state_nx = ST_IDLE;
                end
            end
            ST_IND_REQ: begin
                if (mem_ack) state_nx = mem_err ? ST_IND_FAIL : ST_SUM_REQ;
            end
            ST_IND_FAIL: state_nx = ST_SUM_REQ;
            ST_SUM_REQ: begin
                if (mem_ack) begin
                    if (mem_err)              state_nx = ST_SUM_FAIL;
                    else if (mem_old == 8'h00) state_nx = ST_RAISE;
                    else                      state_nx = ST_IDLE;
                end
            end
            ST_SUM_FAIL: state_nx = ST_IDLE;
            ST_NOFN_ERR: state_nx = ST_IDLE;
            ST_RAISE:    state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        msi_ready  = 1'b0;
        mem_req    = 1'b0;
        sel_sum    = 1'b0;
        irq_strobe = 1'b0;
        err_valid  = 1'b0;
        err_access = 1'b0;
        unique case (state)
            ST_IDLE:     msi_ready = 1'b1;
            ST_IND_REQ:  mem_req = 1'b1;
            ST_IND_FAIL: begin err_valid = 1'b1; err_access = 1'b1; end
            ST_SUM_REQ:  begin mem_req = 1'b1; sel_sum = 1'b1; end
            ST_SUM_FAIL: begin err_valid = 1'b1; err_access = 1'b1; end
            ST_NOFN_ERR: err_valid = 1'b1;
            ST_RAISE:    irq_strobe = 1'b1;
            default:     msi_ready = 1'b0;
        endcase
        accept = msi_ready & msi_valid;
    end

    // R2
    nofn_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !fn_bound) |=> (err_valid && !err_access && !mem_req));

    // R3
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fn_bound && !fn_enabled) |=> (msi_ready && !mem_req && !err_valid && !irq_strobe));

    // R6
    ind_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fn_bound && fn_enabled) |=> (mem_req && !sel_sum));

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |-> $past(mem_req && sel_sum && mem_ack && !mem_err && (mem_old == 8'h00)));
endmodule

// File: rtl/msib_top.sv
module msib_top
    import msib_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int VEC_W       = 11,
    parameter int OFF_W       = 16,
    parameter int ISC_W       = 3,
    parameter int FIELD_W     = 32,
    parameter int ERR_VEC_LSB = 4,
    localparam int IDX_W      = DATA_W - VEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msi_valid,
    input  logic [ADDR_W-1:0]  msi_addr,
    input  logic [DATA_W-1:0]  msi_data,
    output logic               msi_ready,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               fn_bound,
    input  logic               fn_enabled,
    input  logic [ADDR_W-1:0]  ind_base,
    input  logic [OFF_W-1:0]   ind_off,
    input  logic [ADDR_W-1:0]  sum_base,
    input  logic [OFF_W-1:0]   sum_off,
    input  logic [ISC_W-1:0]   fn_isc,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_mask,
    input  logic               mem_ack,
    input  logic               mem_err,
    input  logic [7:0]         mem_old,
    output logic               irq_strobe,
    output logic [ISC_W-1:0]   irq_isc,
    output logic               err_valid,
    output logic [7:0]         err_code,
    output logic [IDX_W-1:0]   err_index,
    output logic [ADDR_W-1:0]  err_addr,
    output logic [FIELD_W-1:0] err_field
);
    logic              accept, sel_sum, err_access;
    logic [VEC_W-1:0]  vec_in;
    logic [IDX_W-1:0]  idx_in;
    logic [ADDR_W-1:0] ind_addr_c, sum_addr_c;
    logic [7:0]        ind_mask_c, sum_mask_c;

    logic [IDX_W-1:0]  idx_q;
    logic [VEC_W-1:0]  vec_q;
    logic [ADDR_W-1:0] waddr_q, ind_addr_q, sum_addr_q;
    logic [7:0]        ind_mask_q, sum_mask_q;
    logic [ISC_W-1:0]  isc_q;

    assign vec_in  = msi_data[VEC_W-1:0];
    assign idx_in  = msi_data[DATA_W-1:VEC_W];
    assign rd_data = '1;

    msib_bitaddr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .VEC_W(VEC_W)) u_ind_addr (
        .base(ind_base), .off(ind_off), .vec(vec_in),
        .byte_addr(ind_addr_c), .mask(ind_mask_c)
    );

    msib_bitaddr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .VEC_W(1)) u_sum_addr (
        .base(sum_base), .off(sum_off), .vec(1'b0),
        .byte_addr(sum_addr_c), .mask(sum_mask_c)
    );

    msib_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid),
        .fn_bound(fn_bound), .fn_enabled(fn_enabled),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_old(mem_old),
        .msi_ready(msi_ready), .accept(accept), .mem_req(mem_req),
        .sel_sum(sel_sum), .irq_strobe(irq_strobe),
        .err_valid(err_valid), .err_access(err_access)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            vec_q      <= '0;
            waddr_q    <= '0;
            ind_addr_q <= '0;
            ind_mask_q <= '0;
            sum_addr_q <= '0;
            sum_mask_q <= '0;
            isc_q      <= '0;
        end else if (accept) begin
            idx_q      <= idx_in;
            vec_q      <= vec_in;
            waddr_q    <= msi_addr;
            ind_addr_q <= ind_addr_c;
            ind_mask_q <= ind_mask_c;
            sum_addr_q <= sum_addr_c;
            sum_mask_q <= sum_mask_c;
            isc_q      <= fn_isc;
        end
    end

    always_comb begin
        mem_addr  = sel_sum ? sum_addr_q : ind_addr_q;
        mem_mask  = sel_sum ? sum_mask_q : ind_mask_q;
        irq_isc   = isc_q;
        err_code  = err_access ? EVT_IND_ACCESS : EVT_NO_FUNC;
        err_index = err_access ? '0 : idx_q;
        err_addr  = err_access ? '0 : waddr_q;
        err_field = err_access ? '0 : (FIELD_W'(vec_q) << ERR_VEC_LSB);
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_mask)));
endmodule

// File: tb/msib_top_test.sv
module msib_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic [31:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic        msi_ready;
    logic [31:0] rd_data;
    logic        fn_bound = 1'b0, fn_enabled = 1'b0;
    logic [31:0] ind_base = '0, sum_base = '0;
    logic [15:0] ind_off = '0, sum_off = '0;
    logic [2:0]  fn_isc = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [7:0]  mem_mask;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [7:0]  mem_old = '0;
    logic        irq_strobe;
    logic [2:0]  irq_isc;
    logic        err_valid;
    logic [7:0]  err_code;
    logic [20:0] err_index;
    logic [31:0] err_addr, err_field;

    int checks = 0, fails = 0;
    logic [7:0]  mem  [256];
    logic [7:0]  pmem [256];
    logic [40:0] exp_mem [$];
    logic [92:0] exp_err [$];
    logic [2:0]  exp_irq [$];
    logic [31:0] first_addr;
    logic        have_first = 1'b0;
    int          wait_cnt = 0, dly = 0;

    always #10 clk = ~clk;

    msib_top uut (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_addr(msi_addr),
        .msi_data(msi_data), .msi_ready(msi_ready), .rd_data(rd_data),
        .fn_bound(fn_bound), .fn_enabled(fn_enabled), .ind_base(ind_base),
        .ind_off(ind_off), .sum_base(sum_base), .sum_off(sum_off), .fn_isc(fn_isc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_mask(mem_mask),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_old(mem_old),
        .irq_strobe(irq_strobe), .irq_isc(irq_isc), .err_valid(err_valid),
        .err_code(err_code), .err_index(err_index), .err_addr(err_addr),
        .err_field(err_field)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        report();
    end

    // memory responder: byte OR with prior value, error above 0xff
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0; mem_err = 1'b0; mem_old = '0;
            end else if (rst_n && mem_req) begin
                if (!have_first) begin
                    first_addr = mem_addr; have_first = 1'b1; wait_cnt = dly;
                end
                if (wait_cnt > 0) wait_cnt--;
                else begin
                    chk(mem_addr == first_addr, "R7", "address held until ack", mem_addr, first_addr);
                    chk(!msi_ready, "R6", "ready low during update", msi_ready, 0);
                    if (exp_mem.size() == 0)
                        chk(1'b0, "R3", "unexpected memory request", mem_addr, 0);
                    else begin
                        logic [40:0] e;
                        e = exp_mem.pop_front();
                        chk({mem_addr, mem_mask} == e[39:0], e[40] ? "R5" : "R4",
                            "request address/mask", {mem_addr, mem_mask}, e[39:0]);
                    end
                    if (mem_addr >= 32'd256) begin
                        mem_err = 1'b1; mem_old = '0;
                    end else begin
                        mem_err = 1'b0;
                        mem_old = mem[mem_addr[7:0]];
                        mem[mem_addr[7:0]] = mem[mem_addr[7:0]] | mem_mask;
                    end
                    mem_ack = 1'b1; have_first = 1'b0; dly = (dly + 1) % 3;
                end
            end
        end
    end

    // event monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && irq_strobe) begin
                if (exp_irq.size() == 0) chk(1'b0, "R8", "unexpected interrupt", irq_isc, 0);
                else begin
                    logic [2:0] ei;
                    ei = exp_irq.pop_front();
                    chk(irq_isc == ei, "R8", "interrupt subclass", irq_isc, ei);
                end
            end
            if (rst_n && err_valid) begin
                if (exp_err.size() == 0)
                    chk(1'b0, "R9", "unexpected event", {err_code, err_index, err_addr, err_field}, 0);
                else begin
                    logic [92:0] ee;
                    ee = exp_err.pop_front();
                    chk({err_code, err_index, err_addr, err_field} == ee,
                        (ee[92:85] == 8'h01) ? "R2" : "R9", "event contents",
                        {err_code, err_index, err_addr, err_field}, ee);
                end
            end
        end
    end

    task automatic send_msi(input logic [31:0] d, input logic [31:0] a);
        int v, ix, ipos, spos;
        logic [31:0] ia, sa;
        logic [7:0]  im, sm, old;
        v  = int'(d[10:0]);      // R1 vector field
        ix = int'(d[31:11]);     // R1 index field
        if (!fn_bound) begin
            exp_err.push_back({8'h01, 21'(ix), a, 32'(v) << 4});
        end else if (fn_enabled) begin
            ipos = int'(ind_off) + v;
            ia = ind_base + 32'(ipos / 8);
            im = 8'h80 >> (ipos % 8);
            exp_mem.push_back({1'b0, ia, im});
            if (ia >= 32'd256) exp_err.push_back({8'h02, 85'd0});
            else pmem[ia[7:0]] = pmem[ia[7:0]] | im;
            spos = int'(sum_off);
            sa = sum_base + 32'(spos / 8);
            sm = 8'h80 >> (spos % 8);
            exp_mem.push_back({1'b1, sa, sm});
            if (sa >= 32'd256) exp_err.push_back({8'h02, 85'd0});
            else begin
                old = pmem[sa[7:0]];
                pmem[sa[7:0]] = old | sm;
                if (old == 8'h00) exp_irq.push_back(fn_isc);
            end
        end
        @(negedge clk);
        while (!msi_ready) @(negedge clk);
        msi_valid = 1'b1; msi_data = d; msi_addr = a;
        @(negedge clk);
        msi_valid = 1'b0;
        if (fn_bound && !fn_enabled)
            chk(msi_ready, "R3", "ready right after dropped write", msi_ready, 1);
        while (!msi_ready) @(negedge clk);
        @(negedge clk);
        chk(exp_mem.size() == 0, "R6", "all requests seen", exp_mem.size(), 0);
        chk(exp_err.size() == 0, "R9", "all events seen", exp_err.size(), 0);
        chk(exp_irq.size() == 0, "R8", "all interrupts seen", exp_irq.size(), 0);
    endtask

    initial begin
        int bad;
        for (int i = 0; i < 256; i++) begin mem[i] = '0; pmem[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(msi_ready && !mem_req && !irq_strobe && !err_valid, "R11", "reset outputs",
            {msi_ready, mem_req, irq_strobe, err_valid}, 4'b1000);
        // R10 window read
        chk(rd_data == 32'hffffffff, "R10", "window read", rd_data, 32'hffffffff);

        // R4 R5 R8 first vector, summary clear -> interrupt
        fn_bound = 1; fn_enabled = 1; fn_isc = 3'd5;
        ind_base = 32'h10; ind_off = 0; sum_base = 32'h40; sum_off = 3;
        send_msi({21'd7, 11'd0}, 32'h1000);
        // R4 byte crossing; summary already set -> no interrupt (R8)
        ind_off = 5;
        send_msi({21'd7, 11'd10}, 32'h1000);
        // R9 indicator out of range, summary still updated and interrupts
        sum_off = 11;
        send_msi({21'd7, 11'd2047}, 32'h1004);
        // R3 disabled function: dropped
        fn_enabled = 0;
        send_msi({21'd7, 11'd1}, 32'h1000);
        // R2 unbound function
        fn_bound = 0;
        send_msi({21'h1ABCD, 11'h155}, 32'h1234);
        // R9 summary out of range: event, no interrupt
        fn_bound = 1; fn_enabled = 1; fn_isc = 3'd2;
        ind_base = 32'h20; ind_off = 0; sum_base = 32'h200; sum_off = 0;
        send_msi({21'd3, 11'd4}, 32'h2000);
        // R8 indicator and summary share a byte: summary sees nonzero byte
        ind_base = 32'h80; sum_base = 32'h80;
        send_msi({21'd3, 11'd1}, 32'h2000);
        // R8 foreign bit set in summary byte suppresses interrupt
        mem[8'h90] = 8'h01; pmem[8'h90] = 8'h01;
        ind_base = 32'h30; sum_base = 32'h90; sum_off = 0;
        send_msi({21'd3, 11'd9}, 32'h2000);
        // R8 fresh summary byte with other subclass interrupts
        fn_isc = 3'd6; sum_base = 32'hA0; sum_off = 7;
        send_msi({21'd3, 11'd9}, 32'h2000);

        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != pmem[i]) bad++;
        chk(bad == 0, "R4", "indicator memory contents", bad, 0);
        chk(rd_data == 32'hffffffff, "R10", "window read after traffic", rd_data, 32'hffffffff);
        report();
    end
endmodule